// File: doc/BRIEF.md
# Full-Speed Frame Timer

This block keeps the frame clock of a full-speed host controller. It advances one step on every pulse of a 12 MHz bit-time enable. It divides that count into frames of a programmable number of bit times. At each frame boundary it emits a start-of-frame pulse and advances a frame number. Inside each frame it gives two timing decisions to the list-processing logic. The first is a window that says periodic work may begin. The second is a fit flag that says whether a transaction of a given length in bit times can still complete before end-of-frame work has to start.

The fit flag is based on a second down-counter. This counter holds a packet budget and is reloaded at every boundary. Software chooses the budget as the frame interval less the transaction overhead, derated by 6/7 to cover worst-case bit stuffing. With the default interval of 12000 and an overhead of 210 bit times, the budget is (12000 - 210) * 6 / 7 = 10105. The periodic threshold defaults to 90% of the interval, which is 10800.

Configuration is written through a small write-only port. All written values wait in pending registers until the next frame boundary, so the frame in progress is never reshaped. Frame intervals below 2 bit times are not supported.

Top module: `sof_frame_timer`

## Requirements
- R1: After reset, sof_pulse, frame_num and periodic_win are 0. The interval is 12000, the budget is 10105 and the periodic threshold is 10800. Before any bit-time enable, xact_fits is 1 for xact_len 10105 and 0 for xact_len 10106.
- R2: With an active interval I, sof_pulse is high for one clock on the bit time that ends a frame. The first frame after reset ends on the I-th enabled bit time. Each later frame ends I enabled bit times after the previous boundary.
- R3: frame_num increases by exactly one at each boundary and is updated in the same clock that sof_pulse is high. At no other time does it change.
- R4: Within a frame, count k bit times from the boundary. periodic_win is high when I-1-k <= P and k < I, where P is the active threshold. It is low in the clock of sof_pulse and for all earlier bit times of the frame.
- R5: At each boundary the budget is loaded with the value written in bits 30:16 of the frame word. After that it falls by one per bit time and stops at 0. xact_fits is 1 exactly when xact_len <= budget.
- R6: xact_grant is 1 exactly when xact_req and xact_fits are both 1.
- R7: A write with cfg_sel=0 carries the interval in bits 13:0 and the budget in bits 30:16. A write with cfg_sel=1 carries the threshold in bits 13:0. Any write made within a frame does not change that frame's length, window or budget. The written values take effect from the next boundary.
- R8: In a clock with bit_en low, sof_pulse is 0 and frame_num, periodic_win, the budget and the fit result do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-clock pulse per full-speed bit time |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the frame word, 1 selects the periodic threshold |
| cfg_wdata | input | 32 | Write data: interval in 13:0 and budget in 30:16, or threshold in 13:0 |
| xact_req | input | 1 | Request to start a transaction |
| xact_len | input | 15 | Length of the requested transaction in bit times |
| xact_fits | output | 1 | Transaction of xact_len fits in the remaining budget |
| xact_grant | output | 1 | Request granted |
| sof_pulse | output | 1 | One-clock start-of-frame pulse |
| frame_num | output | 16 | Frame number |
| periodic_win | output | 1 | Periodic processing may begin |

## Verification
The bench sweeps every threshold from 0 to I-2 for short intervals, each with a budget of zero, a budget smaller than the frame and a budget longer than the frame. This catches a window that opens one bit time early or late and a budget that wraps below zero instead of holding there; a wrapping design would suddenly grant huge transactions near the end of a frame. On every frame the next configuration is written during the first two bit times, so a design that applied writes at once would shorten or lengthen the frame in progress or shift its window. Alternate configurations put an idle clock between bit times, which exposes a design that counts clocks instead of enables or that stretches the start-of-frame pulse.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, reset defaults and write-select encoding for the
// full-speed frame timer. Defaults follow from a 1 ms frame at 12 Mbit/s.
package sft_pkg;
    localparam int INTERVAL_W    = 14;
    localparam int BUDGET_W      = 15;
    localparam int FRNUM_W       = 16;
    localparam int CFG_W         = 32;
    localparam int BUDGET_LSB    = 16;
    localparam int DEF_INTERVAL  = 12000;
    localparam int OVERHEAD_BITS = 210;
    localparam int DEF_BUDGET    = ((DEF_INTERVAL - OVERHEAD_BITS) * 6) / 7;
    localparam int DEF_PSTART    = (DEF_INTERVAL * 90) / 100;

    typedef enum logic {
        SEL_FRAME  = 1'b0,
        SEL_PSTART = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/sft_cfg_regs.sv
`timescale 1ns/1ps
// Module: sft_cfg_regs
// Holds the pending frame word (interval, budget) and pending periodic
// threshold written by software, plus the active threshold copied at each
// frame boundary. Assumes the interval field sits below BUDGET_LSB and the
// budget field fits inside the write word. Reserved bits are ignored.
module sft_cfg_regs #(
    parameter int IW     = 14,
    parameter int BW     = 15,
    parameter int CW     = 32,
    parameter int BLSB   = 16,
    parameter int DEF_I  = 12000,
    parameter int DEF_B  = 10105,
    parameter int DEF_P  = 10800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic          frame_end,
    output logic [IW-1:0] pend_interval,
    output logic [BW-1:0] pend_budget,
    output logic [IW-1:0] act_pstart
);
    import sft_pkg::*;

    localparam int BTOP = BLSB + BW;

    logic [IW-1:0] pend_pstart;
    logic          unused_rsvd_lo;

    // Reserved bits between the interval and budget fields.
    assign unused_rsvd_lo = ^wr_data[BLSB-1:IW];

    generate
        if (CW > BTOP) begin : g_rsvd_hi
            logic unused_rsvd_hi;
            // Reserved bits above the budget field.
            assign unused_rsvd_hi = ^wr_data[CW-1:BTOP];
        end
    endgenerate

    // Capture software writes into the pending registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_interval <= IW'(DEF_I);
            pend_budget   <= BW'(DEF_B);
            pend_pstart   <= IW'(DEF_P);
        end else if (wr_en) begin
            if (cfg_sel_e'(wr_sel) == SEL_FRAME) begin
                pend_interval <= wr_data[IW-1:0];
                pend_budget   <= wr_data[BLSB +: BW];
            end else begin
                pend_pstart   <= wr_data[IW-1:0];
            end
        end
    end

    // Move the threshold into service only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pstart <= IW'(DEF_P);
        end else if (frame_end) begin
            act_pstart <= pend_pstart;
        end
    end
endmodule

// File: rtl/sft_frame_ctr.sv
`timescale 1ns/1ps
// Module: sft_frame_ctr
// Counts the bit times left in the frame down to zero. On the bit time at
// zero it reloads from the pending interval, pulses start-of-frame and bumps
// the frame number. It also keeps the periodic window, which opens once the
// remaining count is at or below the active threshold. Assumes intervals of
// at least 2.
module sft_frame_ctr #(
    parameter int IW    = 14,
    parameter int FW    = 16,
    parameter int DEF_I = 12000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic [IW-1:0] reload_interval,
    input  logic [IW-1:0] pstart,
    output logic          frame_end,
    output logic          sof_pulse,
    output logic [FW-1:0] frame_num,
    output logic          periodic_win
);
    logic [IW-1:0] remain;
    logic [IW-1:0] remain_dec;

    // Next remaining count when a bit time passes within the frame.
    assign remain_dec = remain - IW'(1);
    // Boundary strobe: the last bit time of the frame is being consumed.
    assign frame_end  = bit_en && (remain == '0);

    // Remaining-bit-time down-counter with reload at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= IW'(DEF_I - 1);
        end else if (frame_end) begin
            remain <= reload_interval - IW'(1);
        end else if (bit_en) begin
            remain <= remain_dec;
        end
    end

    // Start-of-frame pulse, one clock wide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_pulse <= 1'b0;
        end else begin
            sof_pulse <= frame_end;
        end
    end

    // Frame number, advanced at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_num <= '0;
        end else if (frame_end) begin
            frame_num <= frame_num + FW'(1);
        end
    end

    // Periodic window: set at the threshold, cleared at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periodic_win <= 1'b0;
        end else if (frame_end) begin
            periodic_win <= 1'b0;
        end else if (bit_en && (remain_dec <= pstart)) begin
            periodic_win <= 1'b1;
        end
    end
endmodule

// File: rtl/sft_budget_ctr.sv
`timescale 1ns/1ps
// Module: sft_budget_ctr
// Holds the stuffing-derated packet budget for the current frame. It is
// reloaded at each boundary and falls by one per bit time, holding at zero.
// A request is granted only if its length does not exceed the budget left.
module sft_budget_ctr #(
    parameter int BW    = 15,
    parameter int DEF_B = 10105
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          frame_end,
    input  logic [BW-1:0] load_value,
    input  logic          xact_req,
    input  logic [BW-1:0] xact_len,
    output logic [BW-1:0] budget,
    output logic          xact_fits,
    output logic          xact_grant
);
    // Budget counter: reload at boundary, saturating decrement per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            budget <= BW'(DEF_B);
        end else if (frame_end) begin
            budget <= load_value;
        end else if (bit_en && (budget != '0)) begin
            budget <= budget - BW'(1);
        end
    end

    // Fit decision and grant for the requested length.
    always_comb begin
        xact_fits  = (xact_len <= budget);
        xact_grant = xact_req && xact_fits;
    end
endmodule

// File: rtl/sof_frame_timer.sv
`timescale 1ns/1ps
// Module: sof_frame_timer (top)
// Full-speed frame timer: frame counter, packet budget counter and their
// configuration registers. Assumes bit_en is a one-clock pulse per bit time
// and that software never programs an interval below 2.
module sof_frame_timer #(
    parameter int INTERVAL_W = sft_pkg::INTERVAL_W,
    parameter int BUDGET_W   = sft_pkg::BUDGET_W,
    parameter int FRNUM_W    = sft_pkg::FRNUM_W,
    parameter int CFG_W      = sft_pkg::CFG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                cfg_wr_en,
    input  logic                cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                xact_req,
    input  logic [BUDGET_W-1:0] xact_len,
    output logic                xact_fits,
    output logic                xact_grant,
    output logic                sof_pulse,
    output logic [FRNUM_W-1:0]  frame_num,
    output logic                periodic_win
);
    import sft_pkg::*;

    logic                  frame_end;
    logic [INTERVAL_W-1:0] pend_interval;
    logic [BUDGET_W-1:0]   pend_budget;
    logic [INTERVAL_W-1:0] pstart_act;
    logic [BUDGET_W-1:0]   budget_cnt;

    sft_cfg_regs #(
        .IW    (INTERVAL_W),
        .BW    (BUDGET_W),
        .CW    (CFG_W),
        .BLSB  (BUDGET_LSB),
        .DEF_I (DEF_INTERVAL),
        .DEF_B (DEF_BUDGET),
        .DEF_P (DEF_PSTART)
    ) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (cfg_wr_en),
        .wr_sel        (cfg_sel),
        .wr_data       (cfg_wdata),
        .frame_end     (frame_end),
        .pend_interval (pend_interval),
        .pend_budget   (pend_budget),
        .act_pstart    (pstart_act)
    );

    sft_frame_ctr #(
        .IW    (INTERVAL_W),
        .FW    (FRNUM_W),
        .DEF_I (DEF_INTERVAL)
    ) u_frame (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_en          (bit_en),
        .reload_interval (pend_interval),
        .pstart          (pstart_act),
        .frame_end       (frame_end),
        .sof_pulse       (sof_pulse),
        .frame_num       (frame_num),
        .periodic_win    (periodic_win)
    );

    sft_budget_ctr #(
        .BW    (BUDGET_W),
        .DEF_B (DEF_BUDGET)
    ) u_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .frame_end  (frame_end),
        .load_value (pend_budget),
        .xact_req   (xact_req),
        .xact_len   (xact_len),
        .budget     (budget_cnt),
        .xact_fits  (xact_fits),
        .xact_grant (xact_grant)
    );
endmodule

// File: rtl/sft_checker.sv
`timescale 1ns/1ps
// Module: sft_checker
// Temporal properties of the frame timer, attached to the top by bind.
module sft_checker #(
    parameter int IW = 14,
    parameter int BW = 15,
    parameter int FW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic          frame_end,
    input logic [BW-1:0] budget,
    input logic [IW-1:0] pstart_act,
    input logic          sof_pulse,
    input logic [FW-1:0] frame_num,
    input logic          periodic_win
);
    // R2: start-of-frame lasts a single clock.
    assert_sof_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> !sof_pulse);

    // R3: frame number steps by one alongside the pulse.
    assert_frnum_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> (frame_num == $past(frame_num) + FW'(1)));

    // R3: frame number holds between pulses.
    assert_frnum_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_pulse |-> $stable(frame_num));

    // R4: the window is closed in the start-of-frame clock.
    assert_win_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> !periodic_win);

    // R5: the budget never grows except at a boundary.
    assert_budget_nonrising_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> (budget <= $past(budget)));

    // R7: the threshold in service only changes at a boundary.
    assert_pstart_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> $stable(pstart_act));

    // R8: nothing moves in a clock without a bit time.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> (!sof_pulse && $stable(frame_num) && $stable(budget)
                            && $stable(periodic_win)));
endmodule

bind sof_frame_timer sft_checker #(
    .IW (INTERVAL_W),
    .BW (BUDGET_W),
    .FW (FRNUM_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .frame_end    (frame_end),
    .budget       (budget_cnt),
    .pstart_act   (pstart_act),
    .sof_pulse    (sof_pulse),
    .frame_num    (frame_num),
    .periodic_win (periodic_win)
);

// File: tb/sof_frame_timer_bench.sv
`timescale 1ns/1ps
// Bench: runs the default frame, then sweeps short intervals over every
// threshold and three budgets, writing the next configuration mid-frame.
module sof_frame_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        xact_req = 1'b0;
    logic [14:0] xact_len = '0;
    logic        xact_fits;
    logic        xact_grant;
    logic        sof_pulse;
    logic [15:0] frame_num;
    logic        periodic_win;

    int checks = 0;
    int errors = 0;
    int fn_exp = 0;
    bit done = 1'b0;

    sof_frame_timer u_sof_frame_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .xact_req     (xact_req),
        .xact_len     (xact_len),
        .xact_fits    (xact_fits),
        .xact_grant   (xact_grant),
        .sof_pulse    (sof_pulse),
        .frame_num    (frame_num),
        .periodic_win (periodic_win)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int k, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at bit %0d: actual %0d expected %0d", tag, k, act, exp);
        end
    endtask

    function automatic logic [31:0] frame_word(input int ival, input int bud);
        logic [31:0] w;
        w        = '0;
        w[13:0]  = ival[13:0];
        w[30:16] = bud[14:0];
        return w;
    endfunction

    // One clock with bit_en set as given; returns at the next falling edge.
    task automatic tick(input bit en);
        bit_en = en;
        @(negedge clk);
        bit_en    = 1'b0;
        cfg_wr_en = 1'b0;
    endtask

    // Check all outputs against the expected frame state.
    task automatic sample(input bit idle, input int k, input bit exp_sof,
                          input bit exp_win, input int exp_bud);
        chk(idle ? "R8" : "R2 R7", k, int'(sof_pulse), int'(exp_sof));
        chk(idle ? "R8" : "R3", k, int'(frame_num), fn_exp);
        chk(idle ? "R8" : "R4 R7", k, int'(periodic_win), int'(exp_win));
        xact_req = k[0];
        xact_len = 15'(exp_bud);
        #1;
        chk(idle ? "R8" : "R5", k, int'(xact_fits), 1);
        chk("R6", k, int'(xact_grant), int'(k[0]));
        xact_len = 15'(exp_bud + 1);
        #1;
        chk(idle ? "R8" : "R5", k, int'(xact_fits), 0);
        chk("R6", k, int'(xact_grant), 0);
        xact_req = 1'b0;
    endtask

    // Run one frame of the active configuration and write the next one.
    task automatic run_frame(input int ival, input int ps, input int bud,
                             input int n_ival, input int n_ps, input int n_bud,
                             input bit gap);
        for (int k = 1; k <= ival; k++) begin
            bit ew;
            int eb;
            if (k == 1) begin
                cfg_wr_en = 1'b1; cfg_sel = 1'b0; cfg_wdata = frame_word(n_ival, n_bud);
            end else if (k == 2) begin
                cfg_wr_en = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'(n_ps);
            end
            tick(1'b1);
            if (k == ival) fn_exp = (fn_exp + 1) % 65536;
            ew = (k >= ival - 1 - ps) && (k < ival);
            eb = (k == ival) ? n_bud : ((bud > k) ? bud - k : 0);
            sample(1'b0, k, k == ival, ew, eb);
            if (gap && k < ival) begin
                tick(1'b0);
                sample(1'b1, k, 1'b0, ew, eb);
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c_i, c_p, c_b;
        int def_b;
        def_b = ((12000 - 210) * 6) / 7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state before any bit time.
        chk("R1", 0, int'(sof_pulse), 0);
        chk("R1", 0, int'(frame_num), 0);
        chk("R1", 0, int'(periodic_win), 0);
        xact_len = 15'(def_b);
        #1;
        chk("R1", 0, int'(xact_fits), 1);
        xact_len = 15'(def_b + 1);
        #1;
        chk("R1", 0, int'(xact_fits), 0);

        // R1: default frame length, window and budget.
        c_i = 4; c_p = 0; c_b = 0;
        run_frame(12000, 10800, def_b, c_i, c_p, c_b, 1'b0);

        for (int iv = 4; iv <= 15; iv++) begin
            for (int pv = 0; pv <= iv - 2; pv++) begin
                for (int bi = 0; bi < 3; bi++) begin
                    int nb;
                    nb = (bi == 0) ? 0 : ((bi == 1) ? iv / 2 : iv + 5);
                    if (!(iv == 4 && pv == 0 && bi == 0)) begin
                        run_frame(c_i, c_p, c_b, iv, pv, nb, c_p[0]);
                        c_i = iv; c_p = pv; c_b = nb;
                    end
                end
            end
        end
        run_frame(c_i, c_p, c_b, c_i, c_p, c_b, 1'b1);
        run_frame(c_i, c_p, c_b, c_i, c_p, c_b, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule